// File: doc/BRIEF.md
# Tagged Receive Sample FIFO with Interrupt Register Set

This block sits behind a multi-channel sampling front end and buffers its decimated output for software or a DMA engine. Each incoming 24-bit sample arrives with the number of the channel it came from. Samples are stored in a small FIFO and leave through a receive holding register. The channel number is placed in the top byte of each read word.

A register port accepts single-cycle reads and writes of 32-bit registers at byte offsets. Through this port software sees the FIFO levels and two sticky error flags, underrun and overrun. It programs an interrupt mask through separate set and clear addresses, sets a chunk threshold that drives a DMA request, and can issue a software reset that flushes the FIFO. A level interrupt is raised while any status bit that is enabled in the mask is set.

Top module: `pcm_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty, the status register at 0x20 reads 0x02 (bit 1 empty only), the mask at 0x1C reads 0, and irq_o and dma_req_o are low.
- R2: An accepted sample is returned by a read of 0x0C in arrival order as {6'b0, channel[1:0], sample[23:0]}, and each read of 0x0C removes one entry.
- R3: The FIFO holds 16 entries. Status bit 2 (full) is set at 16 entries, and 16 reads of 0x0C empty the FIFO.
- R4: A sample that arrives while the FIFO is full and no read of 0x0C occurs in that cycle is dropped, and it sets sticky status bit 5 (overrun).
- R5: A read of 0x0C while the FIFO is empty returns 0 and sets sticky status bit 4 (underrun).
- R6: A read of 0x20 returns the current status and then clears bits 4 and 5. Bit 0 (data ready, FIFO not empty) and bit 1 (empty) always follow the FIFO level.
- R7: Writing ones to 0x14 sets those mask bits and writing ones to 0x18 clears them. The mask reads back at 0x1C, and a write to 0x1C has no effect.
- R8: irq_o is high exactly when the bitwise AND of status and mask is nonzero.
- R9: The chunk size is mode bits 31:28. When it is nonzero and the FIFO holds at least that many entries, status bit 3 and dma_req_o are high.
- R10: Writing 1 to bit 0 of 0x00 empties the FIFO and clears bits 4 and 5, and leaves the mask and the mode unchanged. Reading 0x00 returns 0.
- R11: A read of 0x50 returns the 12-bit version parameter (default 0x210) in bits 11:0 and zeros above.
- R12: The mode register at 0x04 and the configuration register at 0x08 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe, one sample per cycle |
| smp_chan_i | input | 2 | Channel number of the sample |
| smp_data_i | input | 24 | Sample value |
| reg_valid_i | input | 1 | Register access in this cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |
| dma_req_o | output | 1 | DMA request at the chunk threshold |

## Verification
A table of eight samples, spread over all four channels with varied values, is pushed and read back. This shows that ordering and channel tagging are correct and that no channel field is mixed with the sample bits. A fill of seventeen samples separates the full boundary from the overrun drop, because the first and the sixteenth words must survive while the seventeenth must not. An extra read then produces underrun at the empty boundary. The chunk threshold is crossed one sample at a time, so an off-by-one in the comparison shows up. The mask and the software reset are each checked for what they must leave untouched.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  localparam int ADDR_W = 8;
  localparam int NIRQ   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h08;
  localparam logic [ADDR_W-1:0] A_HOLD = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IEN  = 8'h14;
  localparam logic [ADDR_W-1:0] A_IDIS = 8'h18;
  localparam logic [ADDR_W-1:0] A_IMSK = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ISTA = 8'h20;
  localparam logic [ADDR_W-1:0] A_VER  = 8'h50;

  localparam int B_RDY   = 0;
  localparam int B_EMPTY = 1;
  localparam int B_FULL  = 2;
  localparam int B_CHUNK = 3;
  localparam int B_UDR   = 4;
  localparam int B_OVR   = 5;
endpackage

// File: rtl/rxh_fifo.sv
module rxh_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 26,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             ovr_o,
  output logic             udr_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i && !empty;
  // a pop in the same cycle frees the slot for the incoming sample
  assign do_push = push_i && (!full || do_pop);
  assign ovr_o   = push_i && full && !do_pop;
  assign udr_o   = pop_i && empty;
  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/rxh_irq.sv
module rxh_irq import rxh_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      level_i,
  input  logic            udr_i,
  input  logic            ovr_i,
  input  logic            rd_clr_i,
  input  logic            flush_i,
  input  logic            en_we_i,
  input  logic            dis_we_i,
  input  logic [NIRQ-1:0] wdata_i,
  output logic [NIRQ-1:0] status_o,
  output logic [NIRQ-1:0] mask_o,
  output logic            irq_o
);
  logic [NIRQ-1:0] mask_q;
  logic            udr_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      udr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (flush_i) begin
      udr_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      // a new event in the clearing cycle wins
      udr_q <= (udr_q && !rd_clr_i) || udr_i;
      ovr_q <= (ovr_q && !rd_clr_i) || ovr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_q <= '0;
    else if (en_we_i)  mask_q <= mask_q | wdata_i;
    else if (dis_we_i) mask_q <= mask_q & ~wdata_i;
  end

  assign status_o = {ovr_q, udr_q, level_i};
  assign mask_o   = mask_q;
  assign irq_o    = |(status_o & mask_q);
endmodule

// File: rtl/pcm_rx_fifo.sv
module pcm_rx_fifo import rxh_pkg::*; #(
  parameter int          DEPTH   = 16,
  parameter int          NCH     = 4,
  parameter int          SW      = 24,
  parameter logic [11:0] VERSION = 12'h210,
  localparam int CHW  = $clog2(NCH),
  localparam int EW   = CHW + SW,
  localparam int PADW = 32 - EW,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [CHW-1:0]    smp_chan_i,
  input  logic [SW-1:0]     smp_data_i,
  input  logic              reg_valid_i,
  input  logic              reg_write_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic            rd, wr, pop_w, stat_rd, swrst_w;
  logic [EW-1:0]   head;
  logic [CNTW-1:0] count_w;
  logic            ovr, udr, chunk_hit;
  logic [31:0]     mode_q, cfg_q;
  logic [3:0]      chunk;
  logic [NIRQ-1:0] status_w, mask_w;
  logic [3:0]      level;

  assign rd      = reg_valid_i && !reg_write_i;
  assign wr      = reg_valid_i && reg_write_i;
  assign pop_w   = rd && (reg_addr_i == A_HOLD);
  assign stat_rd = rd && (reg_addr_i == A_ISTA);
  assign swrst_w = wr && (reg_addr_i == A_CTRL) && reg_wdata_i[0];

  rxh_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (swrst_w),
    .push_i  (smp_valid_i),
    .pop_i   (pop_w),
    .wdata_i ({smp_chan_i, smp_data_i}),
    .head_o  (head),
    .count_o (count_w),
    .ovr_o   (ovr),
    .udr_o   (udr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cfg_q  <= '0;
    end else if (wr) begin
      if (reg_addr_i == A_MODE) mode_q <= reg_wdata_i;
      if (reg_addr_i == A_CFG)  cfg_q  <= reg_wdata_i;
    end
  end

  assign chunk     = mode_q[31:28];
  assign chunk_hit = (chunk != '0) && (count_w >= CNTW'(chunk));

  assign level[B_RDY]   = (count_w != '0);
  assign level[B_EMPTY] = (count_w == '0);
  assign level[B_FULL]  = (count_w == CNTW'(DEPTH));
  assign level[B_CHUNK] = chunk_hit;

  rxh_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .udr_i    (udr),
    .ovr_i    (ovr),
    .rd_clr_i (stat_rd),
    .flush_i  (swrst_w),
    .en_we_i  (wr && (reg_addr_i == A_IEN)),
    .dis_we_i (wr && (reg_addr_i == A_IDIS)),
    .wdata_i  (reg_wdata_i[NIRQ-1:0]),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  assign dma_req_o = chunk_hit;

  always_comb begin
    reg_rdata_o = '0;
    if (rd) begin
      unique case (reg_addr_i)
        A_MODE: reg_rdata_o = mode_q;
        A_CFG:  reg_rdata_o = cfg_q;
        A_HOLD: reg_rdata_o = (count_w == '0) ? '0 : {{PADW{1'b0}}, head};
        A_IMSK: reg_rdata_o = {{(32-NIRQ){1'b0}}, mask_w};
        A_ISTA: reg_rdata_o = {{(32-NIRQ){1'b0}}, status_w};
        A_VER:  reg_rdata_o = {20'b0, VERSION};
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/rxh_checker.sv
module rxh_checker import rxh_pkg::*; #(
  parameter int DEPTH = 16,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            smp_valid_i,
  input logic            pop_w,
  input logic            swrst_w,
  input logic [CNTW-1:0] count_w,
  input logic [NIRQ-1:0] status_w,
  input logic [NIRQ-1:0] mask_w,
  input logic            irq_o,
  input logic            dma_req_o
);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_w <= CNTW'(DEPTH));

  p_level_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_w[B_RDY] != status_w[B_EMPTY]);

  p_ovr_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && count_w == CNTW'(DEPTH) && !pop_w && !swrst_w) |=> status_w[B_OVR]);

  p_ovr_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && count_w == CNTW'(DEPTH) && !pop_w && !swrst_w) |=> count_w == CNTW'(DEPTH));

  p_udr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_w && count_w == '0 && !swrst_w) |=> status_w[B_UDR]);

  p_irq_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_w & mask_w));

  p_dma_chunk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o == status_w[B_CHUNK]);

  p_swrst_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_w |=> (count_w == '0) && !status_w[B_UDR] && !status_w[B_OVR]);

  p_swrst_mask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_w |=> $stable(mask_w));
endmodule

bind pcm_rx_fifo rxh_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .pop_w       (pop_w),
  .swrst_w     (swrst_w),
  .count_w     (count_w),
  .status_w    (status_w),
  .mask_w      (mask_w),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/sim_pcm_rx_fifo.sv
`timescale 1ns/1ps
module sim_pcm_rx_fifo;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [1:0]  smp_chan_i = '0;
  logic [23:0] smp_data_i = '0;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, dma_req_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pcm_rx_fifo u0 (.*);

  localparam logic [25:0] VEC [8] = '{
    {2'd0, 24'h000001}, {2'd1, 24'hFFFFFF}, {2'd2, 24'h800000}, {2'd3, 24'h7FFFFF},
    {2'd3, 24'h123456}, {2'd0, 24'hA5A5A5}, {2'd2, 24'h5A5A5A}, {2'd1, 24'h000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] d);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_chan_i = ch; smp_data_i = d;
    @(posedge clk_i); #1;
    smp_valid_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h20, v); check("R1 status", v, 32'h02);
    rd(8'h1C, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 dma", {31'b0, dma_req_o}, 32'h0);

    // R2 table walk: order and channel tag
    for (int i = 0; i < 8; i++) push(VEC[i][25:24], VEC[i][23:0]);
    for (int i = 0; i < 8; i++) begin
      rd(8'h0C, v); check("R2 word", v, {6'b0, VEC[i]});
    end

    // R12 mode/config
    wr(8'h04, 32'h4000_0000); rd(8'h04, v); check("R12 mode", v, 32'h4000_0000);
    wr(8'h08, 32'h0055_0011); rd(8'h08, v); check("R12 cfg", v, 32'h0055_0011);

    // R9 chunk threshold of 4
    for (int i = 0; i < 3; i++) push(2'd0, 24'(i));
    check("R9 dma below", {31'b0, dma_req_o}, 32'h0);
    rd(8'h20, v); check("R9 status below", v, 32'h01);
    push(2'd0, 24'd3);
    check("R9 dma at", {31'b0, dma_req_o}, 32'h1);
    rd(8'h20, v); check("R9 status at", v, 32'h09);

    // R7 / R8 mask and irq
    wr(8'h14, 32'h01);
    check("R8 irq on", {31'b0, irq_o}, 32'h1);
    wr(8'h1C, 32'hFF);
    rd(8'h1C, v); check("R7 mask ro", v, 32'h01);
    wr(8'h18, 32'h01);
    rd(8'h1C, v); check("R7 mask cleared", v, 32'h0);
    check("R8 irq off", {31'b0, irq_o}, 32'h0);
    for (int i = 0; i < 4; i++) rd(8'h0C, v);

    // R3 / R4 fill past full
    for (int i = 0; i < 17; i++) push(2'(i % 4), 24'(i + 100));
    rd(8'h20, v); check("R4 status ovr+full", v, 32'h2D);
    rd(8'h20, v); check("R6 ovr cleared", v, 32'h0D);
    for (int i = 0; i < 16; i++) begin
      rd(8'h0C, v);
      if (i == 0 || i == 15) check("R3 drain word", v, {6'b0, 2'(i % 4), 24'(i + 100)});
    end
    rd(8'h20, v); check("R3 empty after 16", v, 32'h02);

    // R5 underrun
    rd(8'h0C, v); check("R5 read empty", v, 32'h0);
    wr(8'h14, 32'h10);
    check("R8 irq udr", {31'b0, irq_o}, 32'h1);
    rd(8'h20, v); check("R5 status udr", v, 32'h12);
    check("R6 irq after clear", {31'b0, irq_o}, 32'h0);
    wr(8'h18, 32'h10);

    // R10 software reset
    for (int i = 0; i < 17; i++) push(2'd1, 24'(i));
    wr(8'h14, 32'h01);
    wr(8'h00, 32'h1);
    rd(8'h20, v); check("R10 status", v, 32'h02);
    rd(8'h1C, v); check("R10 mask kept", v, 32'h01);
    rd(8'h04, v); check("R10 mode kept", v, 32'h4000_0000);
    rd(8'h00, v); check("R10 ctrl read", v, 32'h0);
    check("R10 irq", {31'b0, irq_o}, 32'h0);

    // R11 version
    rd(8'h50, v); check("R11 version", v, 32'h210);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule